// File: doc/BRIEF.md
# Scan Test Sequencer with Partial-Clock Hold Control

This block sits on the tester side of a scan interface and applies an ordered list of scan vectors to a core whose scan chains are split into two groups. The always-clocked group is set A. The group whose clock can be withheld is set B. For each stored vector the sequencer runs a load phase of `CHAIN_LEN` shift cycles and then a single capture cycle. While a vector is being loaded, the response captured for the previous vector is unloaded on the serial outputs. After the last capture, a final unload pass of `CHAIN_LEN` cycles empties the chains and the sequencer reports completion.

Each stored vector carries one flag bit. The flag marks the vector either as partial-observability, which permits withholding the set-B clock, or as full-observability. The sequencer turns these flags into the hold line `hold_b`. The line is raised in time for the capture of a flagged vector and stays up through the next vector's load, so set B neither captures nor shifts and keeps the earlier values. It is lowered for the capture of an unflagged vector. The first vector is always loaded with the hold line low, so that set B receives its values. The last stored vector is always treated as full-observability. As a power estimate, the block keeps a model of the scan flip-flops and accumulates two totals: clocked flip-flop edges and flip-flop output transitions.

The controller has five states: `ST_IDLE` (after reset), `ST_SHIFT`, `ST_CAPTURE`, `ST_FLUSH` and `ST_DONE`. Its transitions are:
- start: `ST_IDLE` or `ST_DONE` to `ST_SHIFT`.
- load complete: `ST_SHIFT` to `ST_CAPTURE`.
- next vector: `ST_CAPTURE` to `ST_SHIFT`, when more vectors remain.
- last vector: `ST_CAPTURE` to `ST_FLUSH`.
- unload complete: `ST_FLUSH` to `ST_DONE`.

Top module: `scan_disable_seq`

## Requirements
- R1: A start pulse accepted in `ST_IDLE` or `ST_DONE` is followed by exactly `CHAIN_LEN` cycles with `shift_en` high and `cap_en` low, then one cycle with `cap_en` high and `shift_en` low.
- R2: In the capture cycle, every set-A chain loads its slice of `cap_data`, and a set-B chain loads its slice only when `hold_b` is low. Chain c's slice is `cap_data[c*CHAIN_LEN +: CHAIN_LEN]`. Chains 0 to `A_CHAINS-1` are set A and the rest are set B.
- R3: `hold_b` changes value only on entry to a capture cycle. There it takes the effective flag of the vector being captured, and it keeps that value through the following load phase.
- R4: `hold_b` is low during the whole load of the first vector. It is also low in the capture of the last stored vector, whatever that vector's flag.
- R5: `scan_out[c]` is the most significant bit of chain c. `unload_vld` is high during every load phase except the first and during the final unload pass. A set-B chain does not shift while `hold_b` is high.
- R6: After the last capture, `CHAIN_LEN` unload cycles run with `scan_in` all zero. After that, `done` rises and stays high, with `shift_en` and `cap_en` low, until the next start.
- R7: `clk_count` is cleared at start. In each shift or capture cycle it grows by `A_CHAINS*CHAIN_LEN`, plus `B_CHAINS*CHAIN_LEN` when `hold_b` is low. In idle and done cycles it is unchanged.
- R8: `tog_count` is cleared at start and then adds, for every clock edge, the number of scan flip-flops that changed value at that edge.
- R9: A write stores `wr_data` at vector slot `wr_addr`. Bit 0 is the flag (1 = partial-observability). Chain c's pattern is at bits `[1 + c*CHAIN_LEN +: CHAIN_LEN]` and is shifted most significant bit first on `scan_in[c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Vector store write strobe |
| wr_addr | input | AW | Vector slot to write |
| wr_data | input | 1+NCH*CHAIN_LEN | Vector word: flag and chain patterns |
| start | input | 1 | Begin applying the stored vector list |
| cap_data | input | NCH*CHAIN_LEN | Core response presented for capture |
| shift_en | output | 1 | Chains shift this cycle |
| cap_en | output | 1 | Chains capture this cycle |
| hold_b | output | 1 | Withholds the clock of set B when high |
| scan_in | output | NCH | Serial data into each chain |
| scan_out | output | NCH | Serial data out of each chain |
| unload_vld | output | 1 | `scan_out` carries a response bit |
| done | output | 1 | Sequence complete |
| clk_count | output | CW | Clocked flip-flop edge total |
| tog_count | output | CW | Flip-flop output transition total |

## Verification
The sequence is first run with a directed flag pattern: a flagged first vector, a run of flagged vectors, one unflagged vector, and a flagged last vector. This shows that the first load is forced full, that the hold line is held across a load, and that the last vector is overridden. A second run with all flags clear shows the plain shift/capture cadence, with both groups always clocked, against the edge and toggle totals. Further runs use random flags, patterns and responses from a fixed seed. In those runs the serial output compared each cycle tells a set-B chain that wrongly shifted or captured apart from one that correctly held, and the totals tell a miscounted held cycle apart from a correct one.

// File: rtl/scanpow_pkg.sv
package scanpow_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SHIFT   = 3'd1,
        ST_CAPTURE = 3'd2,
        ST_FLUSH   = 3'd3,
        ST_DONE    = 3'd4
    } seq_state_t;
endpackage

// File: rtl/scan_vec_store.sv
module scan_vec_store #(
    parameter int NUM_VEC = 8,
    parameter int VW      = 65,
    parameter int AW      = 3
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [VW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [VW-1:0] rd_word
);
    logic [VW-1:0] mem [NUM_VEC];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < NUM_VEC)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_idx) < NUM_VEC) begin
            rd_word = mem[rd_idx];
        end
    end
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
    import scanpow_pkg::*;
#(
    parameter int NUM_VEC   = 8,
    parameter int CHAIN_LEN = 16,
    parameter int AW        = 3,
    parameter int BW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          vec_flag,
    output logic [AW-1:0] vec_idx,
    output logic [BW-1:0] bit_cnt,
    output logic          start_acc,
    output logic          load_phase,
    output logic          shift_en,
    output logic          cap_en,
    output logic          unload_vld,
    output logic          hold_b,
    output logic          done
);
    localparam logic [AW-1:0] LAST_VEC = AW'(NUM_VEC - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(CHAIN_LEN - 1);

    seq_state_t state_q, state_d;
    logic       last_bit, last_vec, eff_flag;

    assign last_bit  = (bit_cnt == LAST_BIT);
    assign last_vec  = (vec_idx == LAST_VEC);
    assign eff_flag  = vec_flag && !last_vec;
    assign start_acc = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start)    state_d = ST_SHIFT;
            ST_SHIFT:         if (last_bit) state_d = ST_CAPTURE;
            ST_CAPTURE:       state_d = last_vec ? ST_FLUSH : ST_SHIFT;
            ST_FLUSH:         if (last_bit) state_d = ST_DONE;
            default:          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            vec_idx <= '0;
            hold_b  <= 1'b0;
        end else if (start_acc) begin
            bit_cnt <= '0;
            vec_idx <= '0;
            hold_b  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SHIFT: begin
                    if (last_bit) begin
                        bit_cnt <= '0;
                        hold_b  <= eff_flag;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_CAPTURE: if (!last_vec) vec_idx <= vec_idx + 1'b1;
                ST_FLUSH:   bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                default:    ;
            endcase
        end
    end

    always_comb begin
        load_phase = 1'b0;
        shift_en   = 1'b0;
        cap_en     = 1'b0;
        unload_vld = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_SHIFT: begin
                load_phase = 1'b1;
                shift_en   = 1'b1;
                unload_vld = (vec_idx != '0);
            end
            ST_CAPTURE: cap_en = 1'b1;
            ST_FLUSH: begin
                shift_en   = 1'b1;
                unload_vld = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    // R3
    hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_b) |-> (state_q == ST_CAPTURE));

    // R4
    first_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && vec_idx == '0) |-> !hold_b);

    // R4
    last_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && last_vec) |-> !hold_b);

    // R1
    single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE) |=> (state_q != ST_CAPTURE));

    // R6
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state_q) == ST_FLUSH));
endmodule

// File: rtl/scan_chain_model.sv
module scan_chain_model #(
    parameter int A_CHAINS  = 2,
    parameter int B_CHAINS  = 2,
    parameter int CHAIN_LEN = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              shift_en,
    input  logic                              cap_en,
    input  logic                              hold_b,
    input  logic [A_CHAINS+B_CHAINS-1:0]      si,
    input  logic [(A_CHAINS+B_CHAINS)*CHAIN_LEN-1:0] cap_data,
    output logic [(A_CHAINS+B_CHAINS)*CHAIN_LEN-1:0] ff_state,
    output logic [A_CHAINS+B_CHAINS-1:0]      so
);
    localparam int NCH  = A_CHAINS + B_CHAINS;
    localparam int A_FF = A_CHAINS * CHAIN_LEN;
    localparam int TOT  = NCH * CHAIN_LEN;

    for (genvar c = 0; c < NCH; c++) begin : g_chain
        logic [CHAIN_LEN-1:0] ch;
        logic                 clk_on;
        if (c < A_CHAINS) begin : g_set_a
            assign clk_on = shift_en || cap_en;
        end else begin : g_set_b
            assign clk_on = (shift_en || cap_en) && !hold_b;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch <= '0;
            end else if (clk_on) begin
                if (cap_en) ch <= cap_data[c*CHAIN_LEN +: CHAIN_LEN];
                else        ch <= {ch[CHAIN_LEN-2:0], si[c]};
            end
        end

        assign ff_state[c*CHAIN_LEN +: CHAIN_LEN] = ch;
        assign so[c] = ch[CHAIN_LEN-1];
    end

    // R5
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_b |=> $stable(ff_state[TOT-1:A_FF]));

    // R2
    a_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (ff_state[A_FF-1:0] == $past(cap_data[A_FF-1:0])));
endmodule

// File: rtl/scan_activity_meter.sv
module scan_activity_meter #(
    parameter int A_FF = 32,
    parameter int B_FF = 32,
    parameter int CW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 active,
    input  logic                 hold_b,
    input  logic [A_FF+B_FF-1:0] ff_state,
    output logic [CW-1:0]        clk_count,
    output logic [CW-1:0]        tog_count
);
    localparam int TOT = A_FF + B_FF;

    logic [TOT-1:0] prev_q;
    logic [CW-1:0]  clk_add, tog_add;

    always_comb begin
        clk_add = '0;
        if (active) clk_add = hold_b ? CW'(A_FF) : CW'(TOT);
        tog_add = CW'($countones(ff_state ^ prev_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= '0;
            clk_count <= '0;
            tog_count <= '0;
        end else begin
            prev_q <= ff_state;
            if (clear) begin
                clk_count <= '0;
                tog_count <= '0;
            end else begin
                clk_count <= clk_count + clk_add;
                tog_count <= tog_count + tog_add;
            end
        end
    end

    // R7
    clk_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (clk_count >= $past(clk_count)));

    // R7
    clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !active) |=> $stable(clk_count));
endmodule

// File: rtl/scan_disable_seq.sv
module scan_disable_seq
    import scanpow_pkg::*;
#(
    parameter int NUM_VEC   = 8,
    parameter int CHAIN_LEN = 16,
    parameter int A_CHAINS  = 2,
    parameter int B_CHAINS  = 2,
    localparam int NCH      = A_CHAINS + B_CHAINS,
    localparam int TOT      = NCH * CHAIN_LEN,
    localparam int VW       = TOT + 1,
    localparam int AW       = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int BW       = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
    localparam int CYCLES   = NUM_VEC * (CHAIN_LEN + 1) + CHAIN_LEN + 1,
    localparam int CW       = $clog2(CYCLES * TOT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [VW-1:0]  wr_data,
    input  logic           start,
    input  logic [TOT-1:0] cap_data,
    output logic           shift_en,
    output logic           cap_en,
    output logic           hold_b,
    output logic [NCH-1:0] scan_in,
    output logic [NCH-1:0] scan_out,
    output logic           unload_vld,
    output logic           done,
    output logic [CW-1:0]  clk_count,
    output logic [CW-1:0]  tog_count
);
    logic [AW-1:0]  vec_idx;
    logic [BW-1:0]  bit_cnt;
    logic [VW-1:0]  rd_word;
    logic [TOT-1:0] ff_state;
    logic           start_acc, load_phase;

    scan_vec_store #(.NUM_VEC(NUM_VEC), .VW(VW), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (vec_idx),
        .rd_word (rd_word)
    );

    scan_seq_fsm #(.NUM_VEC(NUM_VEC), .CHAIN_LEN(CHAIN_LEN), .AW(AW), .BW(BW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vec_flag   (rd_word[0]),
        .vec_idx    (vec_idx),
        .bit_cnt    (bit_cnt),
        .start_acc  (start_acc),
        .load_phase (load_phase),
        .shift_en   (shift_en),
        .cap_en     (cap_en),
        .unload_vld (unload_vld),
        .hold_b     (hold_b),
        .done       (done)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_si
        assign scan_in[c] = load_phase
            ? rd_word[1 + c*CHAIN_LEN + (CHAIN_LEN - 1 - int'(bit_cnt))] : 1'b0;
    end

    scan_chain_model #(.A_CHAINS(A_CHAINS), .B_CHAINS(B_CHAINS), .CHAIN_LEN(CHAIN_LEN)) u_chains (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .cap_en   (cap_en),
        .hold_b   (hold_b),
        .si       (scan_in),
        .cap_data (cap_data),
        .ff_state (ff_state),
        .so       (scan_out)
    );

    scan_activity_meter #(.A_FF(A_CHAINS*CHAIN_LEN), .B_FF(B_CHAINS*CHAIN_LEN), .CW(CW)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_acc),
        .active    (shift_en || cap_en),
        .hold_b    (hold_b),
        .ff_state  (ff_state),
        .clk_count (clk_count),
        .tog_count (tog_count)
    );

    // R6
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_phase) |-> (scan_in == '0));
endmodule

// File: tb/test_scan_disable_seq.sv
module test_scan_disable_seq;
    localparam int NV  = 6;
    localparam int L   = 4;
    localparam int NA  = 2;
    localparam int NB  = 2;
    localparam int NCH = NA + NB;
    localparam int TOT = NCH * L;
    localparam int AW  = $clog2(NV);
    localparam int CW  = $clog2((NV * (L + 1) + L + 1) * TOT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [TOT:0] wr_data = '0;
    logic start = 1'b0;
    logic [TOT-1:0] cap_data = '0;
    logic shift_en, cap_en, hold_b, unload_vld, done;
    logic [NCH-1:0] scan_in, scan_out;
    logic [CW-1:0] clk_count, tog_count;

    int n_checks = 0;
    int n_fail = 0;
    int n_vec = 0;
    logic [TOT-1:0] pat [NV];
    bit flags [NV];

    always #2 clk = ~clk;

    scan_disable_seq #(.NUM_VEC(NV), .CHAIN_LEN(L), .A_CHAINS(NA), .B_CHAINS(NB)) i_scan_disable_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .cap_data(cap_data), .shift_en(shift_en), .cap_en(cap_en),
        .hold_b(hold_b), .scan_in(scan_in), .scan_out(scan_out), .unload_vld(unload_vld),
        .done(done), .clk_count(clk_count), .tog_count(tog_count)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load_vectors();
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = AW'(v);
            wr_data = {pat[v], flags[v]};   // R9 layout
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [NCH-1:0] so_of(input logic [TOT-1:0] m);
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[c] = m[c*L + L - 1];
        return r;
    endfunction

    task automatic run_seq();
        logic [TOT-1:0] mff, old;
        logic [NCH-1:0] si_e;
        bit mh;
        int ce, tg;
        mh = 1'b0; ce = 0; tg = 0;
        @(negedge clk);
        mff = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int v = 0; v < NV; v++) begin
            for (int b = 0; b < L; b++) begin
                if (v == 0 && b == 0) mff = {TOT{1'bx}};
                chk(shift_en === 1'b1 && cap_en === 1'b0, "R1 shift phase", {shift_en, cap_en}, 2'b10);
                chk(hold_b === mh, (v == 0) ? "R4 first load hold" : "R3 hold through load", hold_b, mh);
                chk(unload_vld === (v != 0), "R5 unload valid", unload_vld, (v != 0));
                for (int c = 0; c < NCH; c++) si_e[c] = pat[v][c*L + L - 1 - b];
                chk(scan_in === si_e, "R9 scan_in bit order", scan_in, si_e);
                if (v != 0) chk(scan_out === so_of(mff), "R5 scan_out", scan_out, so_of(mff));
                else mff = (v == 0 && b == 0) ? so_prime() : mff;
                old = mff;
                for (int c = 0; c < NCH; c++)
                    if (c < NA || !mh) mff[c*L +: L] = {mff[c*L +: L-1], si_e[c]};
                ce += NA * L + (mh ? 0 : NB * L);
                tg += $countones(old ^ mff);
                @(negedge clk);
            end
            mh = flags[v] && (v != NV - 1);
            cap_data = TOT'($urandom);
            chk(cap_en === 1'b1 && shift_en === 1'b0, "R1 capture cycle", {cap_en, shift_en}, 2'b10);
            chk(hold_b === mh, (v == NV - 1) ? "R4 last vector full" : "R3 hold at capture", hold_b, mh);
            old = mff;
            for (int c = 0; c < NCH; c++)
                if (c < NA || !mh) mff[c*L +: L] = cap_data[c*L +: L];   // R2
            ce += NA * L + (mh ? 0 : NB * L);
            tg += $countones(old ^ mff);
            @(negedge clk);
        end
        for (int b = 0; b < L; b++) begin
            chk(hold_b === 1'b0 && unload_vld === 1'b1, "R5 final unload", {hold_b, unload_vld}, 2'b01);
            chk(scan_in === '0, "R6 zero fill", scan_in, 0);
            chk(scan_out === so_of(mff), "R2 captured response out", scan_out, so_of(mff));
            old = mff;
            for (int c = 0; c < NCH; c++) mff[c*L +: L] = {mff[c*L +: L-1], 1'b0};
            ce += TOT;
            tg += $countones(old ^ mff);
            @(negedge clk);
        end
        chk(done === 1'b1 && shift_en === 1'b0 && cap_en === 1'b0, "R6 done", {done, shift_en, cap_en}, 3'b100);
        @(negedge clk);
        @(negedge clk);
        chk(done === 1'b1, "R6 done held", done, 1);
        chk(clk_count === CW'(ce), "R7 clock edges", clk_count, ce);
        chk(tog_count === CW'(tg), "R8 toggles", tog_count, tg);
        n_vec += NV;
    endtask

    // Chain state at the first load start equals what the previous run left:
    // all zero after reset or after a final unload pass.
    function automatic logic [TOT-1:0] so_prime();
        return '0;
    endfunction

    initial begin
        int dummy;
        dummy = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        chk(done === 1'b0 && shift_en === 1'b0 && cap_en === 1'b0 && hold_b === 1'b0,
            "R6 reset state", {done, shift_en, cap_en, hold_b}, 0);
        chk(clk_count === '0 && tog_count === '0, "R7 reset counts", {clk_count, tog_count}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clk_count === '0, "R7 idle no edges", clk_count, 0);

        // directed: flagged first, run of flagged, one full, flagged last
        flags = '{1, 1, 1, 0, 1, 1};
        for (int v = 0; v < NV; v++) pat[v] = TOT'($urandom);
        load_vectors();
        run_seq();

        // directed: all full-observability
        flags = '{0, 0, 0, 0, 0, 0};
        for (int v = 0; v < NV; v++) pat[v] = ~pat[v];
        load_vectors();
        run_seq();

        // random mixes
        for (int r = 0; r < 4; r++) begin
            for (int v = 0; v < NV; v++) begin
                flags[v] = bit'($urandom % 2);
                pat[v] = TOT'($urandom);
            end
            load_vectors();
            run_seq();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule